// File: doc/BRIEF.md
# SHA-256 Engine with Selectable Initial Value

This block computes SHA-256 over a message that software has already split into 512-bit blocks. Padding and the appended length field are also done by software before any word is written. Each block enters as sixteen 32-bit writes to one input port. The sixteenth write starts a compression that runs one round per clock. When the rounds finish, the working variables are added into a 256-bit chaining register.

A message begins with an init pulse. This pulse loads the chaining register from one of two sources: the eight standard SHA-256 constants, or eight words that software has programmed beforehand. A flag on the block's sixteenth write marks the last block of the message. After that block completes, the ready flag rises. Software then reads the digest as eight 32-bit words from one output port, each read strobe moving to the next word. A live endian control byte-reverses the words on both the input and output ports, so little-endian software can stream its memory contents straight in.

Top module: `sha256_iv_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `hash_ready` and `busy` are 0 and `dout_data` reads 0.
- R2: The sixteenth accepted `din_valid` write starts a compression. `busy` is 1 from the next cycle for exactly 65 cycles: 64 round cycles plus one fold cycle. Writes presented while `busy` is 1 are ignored and change neither the block contents nor the word count.
- R3: When `msg_init` is pulsed with `cfg_user_iv` = 0, the chaining value becomes the standard SHA-256 initial constants. This holds regardless of what user words were programmed.
- R4: When `msg_init` is pulsed with `cfg_user_iv` = 1, the chaining value becomes the eight user words. User word index 0 supplies digest bits [255:224] and index 7 supplies bits [31:0]; the other indices follow in descending bit order. The user words are stored exactly as written, with no byte reversal, and may be written in any order.
- R5: With `cfg_no_swap` = 0, each `din_data` word and each `dout_data` word is byte-reversed, so byte 0 of the port maps to bits [31:24] of the internal word. With `cfg_no_swap` = 1, words pass through unchanged.
- R6: `hash_ready` rises only in the cycle after the fold of a block whose sixteenth write carried `din_last` = 1. It is 0 while `busy` is 1, 0 after a block written with `din_last` = 0, and cleared by `msg_init`.
- R7: While `hash_ready` is 1, `dout_data` presents digest word 0 (bits [255:224]) first. Each cycle with `dout_rd` = 1 advances to the next, less significant word, and the pointer wraps from word 7 back to word 0.
- R8: Consecutive blocks chain. Each fold adds the eight working variables to the chaining words modulo 2^32, and the next block starts from that sum.
- R9: The single-block digests of "abc" and of the empty message, with the standard initial value, equal the published SHA-256 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_init | input | 1 | Start-of-message pulse; loads the chaining value and clears ready |
| cfg_user_iv | input | 1 | 0 selects the standard initial value, 1 selects the user words (sampled on `msg_init`) |
| cfg_no_swap | input | 1 | 0 byte-reverses input and output words, 1 passes them through |
| iv_wr_en | input | 1 | Write strobe for one user initial-value word |
| iv_wr_idx | input | 3 | Index of the user word being written (0 = most significant) |
| iv_wr_data | input | 32 | User initial-value word |
| din_valid | input | 1 | Message word write strobe |
| din_data | input | 32 | Message word |
| din_last | input | 1 | Marks the current block as the last one (sampled on the sixteenth write) |
| dout_rd | input | 1 | Digest read strobe; advances the output word pointer |
| dout_data | output | 32 | Current digest word |
| busy | output | 1 | Compression in progress; writes are ignored |
| hash_ready | output | 1 | Digest valid |

## Verification
The bench builds the engine with the package's fixed shape: 32-bit words, a 16-word block and 64 rounds. At this shape the published "abc" and empty-message vectors can be compared word for word, in both endian settings. The full 65-cycle busy window can be timed edge by edge while garbage writes hit the input. A two-block message from a user initial value can be compared against a compression model written inside the bench. The pointer wrap after the eighth read is also checked.

// File: rtl/sha256_pkg.sv
// Shared types, constants and bit functions for the SHA-256 engine.
// Assumes 32-bit words; all functions are pure combinational helpers.
package sha256_pkg;
    localparam int WORD_W     = 32;
    localparam int BLK_WORDS  = 16;
    localparam int NUM_ROUNDS = 64;
    localparam int HASH_WORDS = 8;
    localparam int HASH_W     = WORD_W * HASH_WORDS;
    localparam int CNT_W      = $clog2(BLK_WORDS);
    localparam int RND_W      = $clog2(NUM_ROUNDS) + 1;
    localparam int PTR_W      = $clog2(HASH_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HASH_W-1:0] hash_t;

    localparam word_t RC_TAB [NUM_ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    localparam word_t STD_IV_TAB [HASH_WORDS] = '{
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t bswap(word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction
endpackage

// File: rtl/sha256_sched.sv
// Message schedule: a 16-word sliding window.
// Words are written by index while idle; each shift exposes the next W(t)
// at slot 0 and appends the newly expanded word at slot 15.
// Assumes writes and shifts never coincide (the controller guarantees it).
module sha256_sched
    import sha256_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic             shift_en,
    output word_t            wt
);
    word_t win [BLK_WORDS];
    word_t next_w;

    // Expand the next schedule word from the current window.
    always_comb begin
        next_w = small_sig1(win[BLK_WORDS-2]) + win[BLK_WORDS-7]
               + small_sig0(win[1]) + win[0];
    end

    // Load words by index, or slide the window by one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_WORDS; i++) win[i] <= '0;
        end else if (wr_en) begin
            win[wr_idx] <= wr_data;
        end else if (shift_en) begin
            for (int i = 0; i < BLK_WORDS-1; i++) win[i] <= win[i+1];
            win[BLK_WORDS-1] <= next_w;
        end
    end

    assign wt = win[0];
endmodule

// File: rtl/sha256_rounds.sv
// Working variables a..h and one SHA-256 round per enabled cycle.
// load_val carries a in its top word and h in its bottom word.
module sha256_rounds
    import sha256_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  hash_t load_val,
    input  logic  step,
    input  word_t kt,
    input  word_t wt,
    output hash_t state
);
    word_t a, b, c, d, e, f, g, h;
    word_t t1, t2;

    // Round temporaries from the current variables.
    always_comb begin
        t1 = h + big_sig1(e) + ((e & f) ^ (~e & g)) + kt + wt;
        t2 = big_sig0(a) + ((a & b) ^ (a & c) ^ (b & c));
    end

    // Load from the chaining value, or advance one round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {a, b, c, d, e, f, g, h} <= '0;
        end else if (load) begin
            {a, b, c, d, e, f, g, h} <= load_val;
        end else if (step) begin
            h <= g;
            g <= f;
            f <= e;
            e <= d + t1;
            d <= c;
            c <= b;
            b <= a;
            a <= t1 + t2;
        end
    end

    assign state = {a, b, c, d, e, f, g, h};
endmodule

// File: rtl/sha256_chain.sv
// Chaining value, user initial-value words and digest readout.
// Word 0 of every 8-word set is the most significant (bits [255:224]).
// The readout pointer moves only on rd_en and returns to 0 on init or fold.
module sha256_chain
    import sha256_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iv_wr_en,
    input  logic [PTR_W-1:0] iv_wr_idx,
    input  word_t            iv_wr_data,
    input  logic             init,
    input  logic             use_user,
    input  logic             acc_en,
    input  hash_t            acc_val,
    input  logic             rd_en,
    input  logic             no_swap,
    output hash_t            chain_out,
    output word_t            dout
);
    word_t hv [HASH_WORDS];
    word_t uv [HASH_WORDS];
    logic [PTR_W-1:0] ptr;

    // Hold the user initial-value words as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HASH_WORDS; i++) uv[i] <= '0;
        end else if (iv_wr_en) begin
            uv[iv_wr_idx] <= iv_wr_data;
        end
    end

    // Seed the chaining words, or fold the working variables in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HASH_WORDS; i++) hv[i] <= '0;
        end else if (init) begin
            for (int i = 0; i < HASH_WORDS; i++)
                hv[i] <= use_user ? uv[i] : STD_IV_TAB[i];
        end else if (acc_en) begin
            for (int i = 0; i < HASH_WORDS; i++)
                hv[i] <= hv[i] + acc_val[HASH_W-1-WORD_W*i -: WORD_W];
        end
    end

    // Step the readout pointer, most significant word first.
    always_ff @(posedge clk) begin
        if (!rst_n || init || acc_en) ptr <= '0;
        else if (rd_en)                ptr <= ptr + 1'b1;
    end

    for (genvar gi = 0; gi < HASH_WORDS; gi++) begin : g_pack
        assign chain_out[HASH_W-1-WORD_W*gi -: WORD_W] = hv[gi];
    end

    assign dout = no_swap ? hv[ptr] : bswap(hv[ptr]);

    // R8: chaining words change only on init or fold
    a_r8_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !acc_en) |=> ($stable(hv[0]) && $stable(hv[7])));

    // R7: pointer moves only on a read, an init or a fold
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !acc_en && !rd_en) |=> $stable(ptr));

    // R3: standard seed lands in the chaining words
    a_r3_std_iv: assert property (@(posedge clk) disable iff (!rst_n)
        (init && !use_user) |=> (hv[0] == 32'h6a09e667 && hv[7] == 32'h5be0cd19));
endmodule

// File: rtl/sha256_iv_engine.sv
// SHA-256 block engine with a selectable initial value.
// Accepts 16 words per block, runs 64 rounds at one per clock, then folds
// the result into the chaining value in one extra cycle. Assumes software
// has already padded the message and appended its length.
module sha256_iv_engine
    import sha256_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_init,
    input  logic        cfg_user_iv,
    input  logic        cfg_no_swap,
    input  logic        iv_wr_en,
    input  logic [2:0]  iv_wr_idx,
    input  logic [31:0] iv_wr_data,
    input  logic        din_valid,
    input  logic [31:0] din_data,
    input  logic        din_last,
    input  logic        dout_rd,
    output logic [31:0] dout_data,
    output logic        busy,
    output logic        hash_ready
);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BLK_WORDS - 1);
    localparam logic [RND_W-1:0] FOLD_RND  = RND_W'(NUM_ROUNDS);

    logic [CNT_W-1:0] word_cnt;
    logic [RND_W-1:0] rnd;
    logic             busy_q, ready_q, last_q;
    logic             accept, blk_full, step, fold;
    word_t            din_word, wt, kt;
    hash_t            chain_val, work_val;

    // Decode the controller's actions for this cycle.
    always_comb begin
        accept   = din_valid && !busy_q && !msg_init;
        blk_full = accept && (word_cnt == LAST_WORD);
        step     = busy_q && (rnd != FOLD_RND);
        fold     = busy_q && (rnd == FOLD_RND);
        din_word = cfg_no_swap ? din_data : bswap(din_data);
        kt       = RC_TAB[rnd[RND_W-2:0]];
    end

    // Count words, run rounds, fold and raise ready after the last block.
    always_ff @(posedge clk) begin
        if (!rst_n || msg_init) begin
            word_cnt <= '0;
            rnd      <= '0;
            busy_q   <= 1'b0;
            ready_q  <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            if (accept) word_cnt <= word_cnt + 1'b1;
            if (blk_full) begin
                busy_q  <= 1'b1;
                rnd     <= '0;
                last_q  <= din_last;
                ready_q <= 1'b0;
            end else if (step) begin
                rnd <= rnd + 1'b1;
            end else if (fold) begin
                busy_q  <= 1'b0;
                ready_q <= last_q;
            end
        end
    end

    sha256_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_idx   (word_cnt),
        .wr_data  (din_word),
        .shift_en (step),
        .wt       (wt)
    );

    sha256_rounds u_rounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (blk_full),
        .load_val (chain_val),
        .step     (step),
        .kt       (kt),
        .wt       (wt),
        .state    (work_val)
    );

    sha256_chain u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .iv_wr_en   (iv_wr_en),
        .iv_wr_idx  (iv_wr_idx),
        .iv_wr_data (iv_wr_data),
        .init       (msg_init),
        .use_user   (cfg_user_iv),
        .acc_en     (fold),
        .acc_val    (work_val),
        .rd_en      (dout_rd && ready_q),
        .no_swap    (cfg_no_swap),
        .chain_out  (chain_val),
        .dout       (dout_data)
    );

    assign busy       = busy_q;
    assign hash_ready = ready_q;

    // R6: no valid digest while compressing
    a_r6_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !ready_q);

    // R2: busy holds through all round cycles
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !msg_init) |=> busy_q);

    // R2: the fold cycle ends the busy window
    a_r2_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fold && !msg_init) |=> !busy_q);

    // R2: writes during compression do not move the word count
    a_r2_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !msg_init) |=> $stable(word_cnt));

    // R6: ready only rises straight after a fold
    a_r6_ready_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(fold));
endmodule

// File: tb/sha256_iv_engine_tb_top.sv
// Directed bench: known vectors, endian modes, user seed, chaining, timing.
module sha256_iv_engine_tb_top;
    typedef logic [31:0]  w32_t;
    typedef logic [255:0] h256_t;

    localparam w32_t KTB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };
    localparam h256_t STD_IV =
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam h256_t ABC_DIG =
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam h256_t EMPTY_DIG =
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_init = 1'b0, cfg_user_iv = 1'b0, cfg_no_swap = 1'b1;
    logic        iv_wr_en = 1'b0;
    logic [2:0]  iv_wr_idx = '0;
    logic [31:0] iv_wr_data = '0;
    logic        din_valid = 1'b0, din_last = 1'b0, dout_rd = 1'b0;
    logic [31:0] din_data = '0;
    logic [31:0] dout_data;
    logic        busy, hash_ready;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sha256_iv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .msg_init(msg_init),
        .cfg_user_iv(cfg_user_iv), .cfg_no_swap(cfg_no_swap),
        .iv_wr_en(iv_wr_en), .iv_wr_idx(iv_wr_idx), .iv_wr_data(iv_wr_data),
        .din_valid(din_valid), .din_data(din_data), .din_last(din_last),
        .dout_rd(dout_rd), .dout_data(dout_data),
        .busy(busy), .hash_ready(hash_ready)
    );

    // ---- reference model ----
    function automatic w32_t rr(w32_t x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic w32_t sw(w32_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic h256_t ref_compress(h256_t hin, w32_t blk [16]);
        w32_t w [64];
        w32_t v [8];
        w32_t t1, t2;
        h256_t hout;
        for (int t = 0; t < 16; t++) w[t] = blk[t];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KTB[t] + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) hout[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
        return hout;
    endfunction

    // ---- helpers ----
    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic start_msg(input logic user);
        @(negedge clk);
        cfg_user_iv = user;
        msg_init = 1'b1;
        @(negedge clk);
        msg_init = 1'b0;
    endtask

    task automatic push_block(input w32_t blk [16], input logic last);
        for (int i = 0; i < 16; i++) begin
            din_valid = 1'b1;
            din_data  = cfg_no_swap ? blk[i] : sw(blk[i]);
            din_last  = last;
            @(negedge clk);
        end
        din_valid = 1'b0;
        din_last  = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_digest(output h256_t r);
        for (int i = 0; i < 8; i++) begin
            r[255-32*i -: 32] = cfg_no_swap ? dout_data : sw(dout_data);
            dout_rd = 1'b1;
            @(negedge clk);
        end
        dout_rd = 1'b0;
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        chk("R1 ready after reset", {255'd0, hash_ready}, 256'd0);
        chk("R1 busy after reset", {255'd0, busy}, 256'd0);
        chk("R1 dout after reset", {224'd0, dout_data}, 256'd0);
    endtask

    task automatic load_user_iv(input h256_t iv);
        for (int i = 7; i >= 0; i--) begin
            iv_wr_en   = 1'b1;
            iv_wr_idx  = 3'(i);
            iv_wr_data = iv[255-32*i -: 32];
            @(negedge clk);
        end
        iv_wr_en = 1'b0;
    endtask

    task automatic t_abc();
        w32_t blk [16];
        h256_t r;
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0]  = 32'h61626380;
        blk[15] = 32'h00000018;
        cfg_no_swap = 1'b1;
        start_msg(1'b0);
        push_block(blk, 1'b1);
        wait_idle();
        chk("R6 ready after last block", {255'd0, hash_ready}, {255'd0, 1'b1});
        read_digest(r);
        chk("R9 R3 abc digest (user words loaded but not selected)", r, ABC_DIG);
        chk("R7 pointer wraps to word 0", {224'd0, dout_data}, {224'd0, ABC_DIG[255:224]});
    endtask

    task automatic t_empty_swapped();
        w32_t blk [16];
        h256_t r;
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = 32'h80000000;
        cfg_no_swap = 1'b0;
        start_msg(1'b0);
        push_block(blk, 1'b1);
        wait_idle();
        chk("R5 raw swapped first word", {224'd0, dout_data}, {224'd0, sw(EMPTY_DIG[255:224])});
        read_digest(r);
        chk("R9 R5 empty digest in swapped mode", r, EMPTY_DIG);
        cfg_no_swap = 1'b1;
    endtask

    task automatic t_user_iv(input h256_t iv);
        w32_t blk [16];
        h256_t r;
        for (int i = 0; i < 16; i++) blk[i] = 32'h0badf00d ^ (32'h01010101 * 32'(i));
        start_msg(1'b1);
        push_block(blk, 1'b1);
        wait_idle();
        read_digest(r);
        chk("R4 user seed single block", r, ref_compress(iv, blk));
    endtask

    task automatic t_chain_timing(input h256_t iv);
        w32_t ba [16];
        w32_t bb [16];
        h256_t r;
        for (int i = 0; i < 16; i++) begin
            ba[i] = 32'h9e3779b9 * 32'(i + 1);
            bb[i] = (ba[i] ^ 32'h5a5a5a5a) + 32'(i);
        end
        start_msg(1'b1);
        push_block(ba, 1'b0);
        chk("R2 busy one cycle after 16th write", {255'd0, busy}, {255'd0, 1'b1});
        for (int i = 0; i < 10; i++) begin
            din_valid = 1'b1;
            din_data  = 32'hdead0000 + 32'(i);
            @(negedge clk);
        end
        din_valid = 1'b0;
        repeat (54) @(negedge clk);
        chk("R2 busy still high at cycle 64", {255'd0, busy}, {255'd0, 1'b1});
        chk("R6 ready low while busy", {255'd0, hash_ready}, 256'd0);
        @(negedge clk);
        chk("R2 busy low after 65 cycles", {255'd0, busy}, 256'd0);
        chk("R6 ready low after non-last block", {255'd0, hash_ready}, 256'd0);
        push_block(bb, 1'b1);
        wait_idle();
        chk("R6 ready after final block", {255'd0, hash_ready}, {255'd0, 1'b1});
        read_digest(r);
        chk("R8 R2 two-block chained digest", r, ref_compress(ref_compress(iv, ba), bb));
        start_msg(1'b0);
        chk("R6 init clears ready", {255'd0, hash_ready}, 256'd0);
    endtask

    initial begin
        h256_t uiv;
        for (int i = 0; i < 8; i++)
            uiv[255-32*i -: 32] = (32'h01234567 * 32'(i + 1)) ^ 32'hdeadbeef;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_user_iv(uiv);
        t_abc();
        t_empty_swapped();
        t_user_iv(uiv);
        t_chain_timing(uiv);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule